// File: doc/BRIEF.md
# Nine-bit parity transceiver

This block computes odd parity over nine data lanes and shares one bidirectional parity line between two uses. The line is modelled as three signals: an input, an output and an output enable. An active-low transmit control selects the mode. With the control low, the block drives the generated parity bit onto the line, and it holds the local error flag inactive. With the control high, the block releases the line and compares the incoming parity bit against the data. It pulls an active-low error flag low on a mismatch.

Several instances can be combined to cover words wider than nine bits. The parity output of one instance feeds a data lane of another. Every output is a combinational function of the inputs, and no clock is involved. A reset input exists only to model the port staying at high impedance during power sequencing: while reset is asserted, the output enable is held low.

Top module: `parity_xcvr9`

## Requirements
- R1: With reset released (rst_n = 1) and tx_n = 0, par_oe is 1 for every data pattern.
- R2: With tx_n = 1, par_oe is 0 whatever rst_n, data_in and par_in are.
- R3: With tx_n = 0, err_n is 1 for every combination of data_in and par_in.
- R4: With tx_n = 0, par_out is 1 exactly when data_in (lanes 0 to 8) holds an even number of ones, so the ones across data_in and par_out always total an odd number.
- R5: With tx_n = 1, err_n is 0 exactly when the ones in data_in plus par_in total an even number, and 1 when they total an odd number.
- R6: While rst_n = 0, par_oe is 0 in both modes and for every data pattern.
- R7: Three transmitting instances each take nine bits of a 27-bit word. Their par_out signals feed lanes 0, 1 and 2 of a fourth transmitting instance, whose other lanes are tied to 0. That fourth instance's par_out is 1 exactly when the 27-bit word holds an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset; while low, the parity port stays released |
| tx_n | input | 1 | Mode select: 0 = transmit (drive parity), 1 = receive (check parity) |
| data_in | input | 9 | Data lanes 0 to 8 covered by the parity |
| par_in | input | 1 | Parity line as seen from the bus (receive side) |
| par_out | output | 1 | Generated odd-parity bit |
| par_oe | output | 1 | Drive enable for the parity line |
| err_n | output | 1 | Active-low parity error flag, valid in receive mode |

## Verification
The hardest case to reach is a cascade of instances in which a single flipped bit anywhere in a wide word must show up at the last instance's parity output. Without a cascade, a fault in the way the generated bit combines is invisible. The bench therefore builds a four-instance tree over 27 bits and walks a spread of computed words, including all-zero and all-one words, comparing against a population count. Separately, all 512 data patterns are swept in both modes with both parity-line levels. The reset state is checked in both modes as well, so that every lane and every mode pairing is covered.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;
  // Number of data lanes covered by one instance
  localparam int unsigned NUM_LANES = 9;
  typedef logic [NUM_LANES-1:0] lane_vec_t;
endpackage

// File: rtl/parity_xor_tree.sv
// Balanced XOR reduction over WIDTH inputs, laid out as a heap-indexed tree.
module parity_xor_tree #(
  parameter int unsigned WIDTH = 9
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             odd_o
);
  localparam int unsigned DEPTH  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int unsigned LEAVES = 1 << DEPTH;

  logic [2*LEAVES-1:1] node;

  // Leaves: real inputs first, then constant zero padding
  for (genvar li = 0; li < LEAVES; li++) begin : g_leaf
    if (li < WIDTH) begin : g_real
      assign node[LEAVES+li] = vec_i[li];
    end else begin : g_pad
      assign node[LEAVES+li] = 1'b0;
    end
  end

  // Internal nodes combine their two children
  for (genvar ni = 1; ni < LEAVES; ni++) begin : g_node
    assign node[ni] = node[2*ni] ^ node[2*ni+1];
  end

  assign odd_o = node[1];
endmodule

// File: rtl/parity_port_ctl.sv
// Decides when the shared parity line is driven.
module parity_port_ctl (
  input  logic rst_n,
  input  logic tx_n,
  output logic drive_en
);
  logic tx_sel;

  always_comb begin
    tx_sel   = ~tx_n;
    drive_en = 1'b0;
    if (rst_n && tx_sel) begin
      drive_en = 1'b1;
    end
  end
endmodule

// File: rtl/parity_err_eval.sv
// Compares the received parity bit against the data parity.
module parity_err_eval (
  input  logic tx_n,
  input  logic data_odd,
  input  logic line_bit,
  output logic err_n
);
  logic total_odd;

  always_comb begin
    total_odd = data_odd ^ line_bit;
    if (!tx_n) begin
      err_n = 1'b1;
    end else begin
      err_n = total_odd;
    end
  end
endmodule

// File: rtl/parity_xcvr9.sv
module parity_xcvr9
  import parity_xcvr_pkg::*;
#(
  parameter int unsigned LANES = NUM_LANES
) (
  input  logic             rst_n,
  input  logic             tx_n,
  input  logic [LANES-1:0] data_in,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err_n
);
  logic data_odd;

  parity_xor_tree #(.WIDTH(LANES)) u_tree (
    .vec_i (data_in),
    .odd_o (data_odd)
  );

  // Odd parity: drive a one when the data count is even
  assign par_out = ~data_odd;

  parity_port_ctl u_port (
    .rst_n    (rst_n),
    .tx_n     (tx_n),
    .drive_en (par_oe)
  );

  parity_err_eval u_err (
    .tx_n     (tx_n),
    .data_odd (data_odd),
    .line_bit (par_in),
    .err_n    (err_n)
  );
endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
  parameter int unsigned LANES = 9
) (
  input logic             rst_n,
  input logic             tx_n,
  input logic [LANES-1:0] data_in,
  input logic             par_in,
  input logic             par_out,
  input logic             par_oe,
  input logic             err_n
);
  always_comb begin
    if (!rst_n) begin
      AST_OE_LOW_IN_RESET: assert (!par_oe);                          // R6
    end
    if (rst_n && !tx_n) begin
      AST_OE_IN_TX: assert (par_oe);                                  // R1
    end
    if (tx_n) begin
      AST_OE_ONLY_TX: assert (!par_oe);                               // R2
      AST_RX_ERR_EVEN: assert (err_n == ($countones({data_in, par_in}) % 2 == 1)); // R5
    end
    if (!tx_n) begin
      AST_ERR_HIGH_TX: assert (err_n);                                // R3
      AST_TX_TOTAL_ODD: assert ($countones({data_in, par_out}) % 2 == 1); // R4
    end
  end
endmodule

bind parity_xcvr9 parity_xcvr_chk #(.LANES(LANES)) u_chk (
  .rst_n   (rst_n),
  .tx_n    (tx_n),
  .data_in (data_in),
  .par_in  (par_in),
  .par_out (par_out),
  .par_oe  (par_oe),
  .err_n   (err_n)
);

// File: tb/sim_parity_xcvr9.sv
`timescale 1ns/1ps
module sim_parity_xcvr9;
  logic clk;
  logic rst_n;
  logic tx_n;
  logic [8:0] data_in;
  logic par_in;
  logic par_out, par_oe, err_n;

  int total;
  int bad;
  int cycles;

  // Cascade signals
  logic [26:0] word;
  logic p0, p1, p2, pf;
  logic oe0, oe1, oe2, oef, e0, e1, e2, ef;

  parity_xcvr9 u0 (
    .rst_n(rst_n), .tx_n(tx_n), .data_in(data_in), .par_in(par_in),
    .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
  );

  parity_xcvr9 u_c0 (.rst_n(1'b1), .tx_n(1'b0), .data_in(word[8:0]),   .par_in(1'b0),
                     .par_out(p0), .par_oe(oe0), .err_n(e0));
  parity_xcvr9 u_c1 (.rst_n(1'b1), .tx_n(1'b0), .data_in(word[17:9]),  .par_in(1'b0),
                     .par_out(p1), .par_oe(oe1), .err_n(e1));
  parity_xcvr9 u_c2 (.rst_n(1'b1), .tx_n(1'b0), .data_in(word[26:18]), .par_in(1'b0),
                     .par_out(p2), .par_oe(oe2), .err_n(e2));
  parity_xcvr9 u_cf (.rst_n(1'b1), .tx_n(1'b0), .data_in({6'b0, p2, p1, p0}), .par_in(1'b0),
                     .par_out(pf), .par_oe(oef), .err_n(ef));

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (tx_n=%0b data=%03h par_in=%0b)",
               req, act, exp, tx_n, data_in, par_in);
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 200000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=<200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    total = 0;
    bad = 0;
    rst_n = 1'b0; tx_n = 1'b0; data_in = '0; par_in = 1'b0; word = '0;
    #1;
    // Reset state, both modes, a few data patterns (R6)
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 512; d += 73) begin
        tx_n = m[0]; data_in = d[8:0];
        #1;
        check(par_oe == 1'b0, "R6", par_oe, 0);
      end
    end
    rst_n = 1'b1;
    #1;
    // Exhaustive sweep: all data, both modes, both line levels
    for (int m = 0; m < 2; m++) begin
      for (int pl = 0; pl < 2; pl++) begin
        for (int d = 0; d < 512; d++) begin
          int ones;
          tx_n = m[0]; par_in = pl[0]; data_in = d[8:0];
          ones = $countones(d[8:0]);
          #1;
          if (m == 0) begin
            check(par_oe == 1'b1, "R1", par_oe, 1);
            check(err_n == 1'b1, "R3", err_n, 1);
            check(par_out == ((ones % 2) == 0), "R4", par_out, ((ones % 2) == 0));
          end else begin
            check(par_oe == 1'b0, "R2", par_oe, 0);
            check(err_n == (((ones + pl) % 2) == 1), "R5", err_n, (((ones + pl) % 2) == 1));
          end
        end
      end
    end
    // Receive mode while in reset still releases the line (R2, R6)
    rst_n = 1'b0; tx_n = 1'b1; data_in = 9'h1FF; par_in = 1'b1;
    #1;
    check(par_oe == 1'b0, "R2", par_oe, 0);
    rst_n = 1'b1;
    #1;
    // Cascade of four instances over 27 bits (R7)
    for (int k = 0; k < 402; k++) begin
      logic [31:0] w;
      int exp_bit;
      if (k == 400)      w = 32'h0;
      else if (k == 401) w = 32'h07FF_FFFF;
      else               w = (k * 32'h9E37_79B1) ^ (k << 7) ^ (32'h1 << (k % 27));
      word = w[26:0];
      exp_bit = $countones(w[26:0]) % 2;
      #1;
      check(pf == exp_bit[0], "R7", pf, exp_bit);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule